// File: doc/BRIEF.md
# Multi-queue write port selector

This block sits at the write entry of a buffer that holds 32 independent queues. All of its logic runs on one free-running write clock. A host picks the target queue by raising a select enable while it presents an address on the write address bus. The low five address bits name the queue. The upper three bits name one of up to eight cascaded devices. Each write with the active-low write enable asserted is then passed on to queue storage as a one-cycle strobe, together with the queue index and the data word.

A queue change does not take effect at once. A new selection passes through a two-edge pipeline. Writes made on the selecting edge, and on the edge after it, still go to the queue that was current before. From the second edge after the selection on, writes go to the new queue.

A selection whose device bits do not match the device identity deselects this device. Once that selection has passed through the pipeline, the device issues no strobes. Selections are ignored until configuration is reported as done. A selection made in the same cycle as the flag strobe is refused, and the block raises an error pulse instead.

Top module: `mqw_write_selector`

## Requirements
- R1: While reset is high and in the first cycle after it, `q_wr` and `sel_err` are 0. Reset is synchronous and active high.
- R2: After reset, no queue is current and no strobe is issued until the first accepted matching selection has passed through the pipeline.
- R3: While `cfg_done` is 0, a high `sel_en` is ignored and the current queue does not change.
- R4: A selection with `wr_addr[7:5]` equal to `dev_id` targets queue `wr_addr[4:0]`. Queues 0 and 31 are both reachable.
- R5: A write (`wr_en_n` = 0) on the edge that accepts a selection, or on the following edge, goes to the queue that was current before that selection.
- R6: A write made on the second rising edge after an accepted selection, or on any later edge, goes to the newly selected queue.
- R7: A selection is accepted whatever the value of `wr_en_n` on that edge.
- R8: An accepted selection with `wr_addr[7:5]` not equal to `dev_id` deselects the device once it has passed through the pipeline. No strobe is issued after that until a matching selection has passed through the pipeline.
- R9: When `sel_en` and `flag_stb` are both 1 on an edge, the selection is ignored and `sel_err` is 1 for exactly the next cycle. At all other times `sel_err` is 0.
- R10: Outputs are registered. A write on edge t gives `q_wr` = 1 after edge t, with `q_data` equal to the `wr_data` sampled at edge t and `q_idx` equal to the queue that was current at edge t.
- R11: Selections on consecutive edges each take effect two edges after their own selecting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | High once device configuration has finished |
| dev_id | input | 3 | Fixed identity of this device in a cascade |
| sel_en | input | 1 | Queue-select enable |
| flag_stb | input | 1 | Flag strobe; must not coincide with `sel_en` |
| wr_en_n | input | 1 | Write enable, active low |
| wr_addr | input | 8 | [7:5] device, [4:0] queue |
| wr_data | input | 36 | Write data word |
| q_wr | output | 1 | Write strobe to queue storage |
| q_idx | output | 5 | Target queue index |
| q_data | output | 36 | Data to queue storage |
| sel_err | output | 1 | One-cycle pulse when select and flag strobe collide |

## Verification
Two things can fall on the same edge: a write, and the acceptance of a new selection. The bench holds `wr_en_n` low across each selecting edge and the edge after it. It then checks that those strobes carry the old index and that the third strobe carries the new one. Back-to-back selections, and a selection that collides with the flag strobe, are both driven while writes continue. A behavioural model tracks the pending and current queues and judges `q_wr`, `q_idx`, `q_data` and `sel_err` after every edge.

// File: rtl/mqw_pkg.sv
package mqw_pkg;

    localparam int unsigned QUEUE_AW = 5;
    localparam int unsigned DEVID_W  = 3;
    localparam int unsigned ADDR_W   = QUEUE_AW + DEVID_W;
    localparam int unsigned DATA_W   = 36;
    localparam int unsigned SEL_LAT  = 2;
    localparam int unsigned NSTG     = SEL_LAT - 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HIT  = 2'd1,
        SEL_MISS = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e             kind;
        logic [QUEUE_AW-1:0]   idx;
    } sel_t;

    function automatic sel_t decode_addr(input logic [ADDR_W-1:0] addr,
                                         input logic [DEVID_W-1:0] id);
        sel_t s;
        s.idx  = addr[QUEUE_AW-1:0];
        s.kind = (addr[ADDR_W-1:QUEUE_AW] == id) ? SEL_HIT : SEL_MISS;
        return s;
    endfunction

endpackage

// File: rtl/mqw_sel_decode.sv
module mqw_sel_decode
    import mqw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_done,
    input  logic [DEVID_W-1:0] dev_id,
    input  logic               sel_en,
    input  logic               flag_stb,
    input  logic [ADDR_W-1:0]  wr_addr,
    output logic               accept,
    output sel_t               dec,
    output logic               sel_err
);

    logic collide;

    always_comb begin
        collide = sel_en & flag_stb;
        accept  = sel_en & cfg_done & ~flag_stb;
        dec     = decode_addr(wr_addr, dev_id);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_err <= 1'b0;
        end else begin
            sel_err <= collide;
        end
    end

endmodule

// File: rtl/mqw_sel_pipe.sv
module mqw_sel_pipe
    import mqw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  sel_t dec,
    output sel_t cur
);

    logic [NSTG-1:0] stg_v;
    sel_t            stg_s [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_v    <= '0;
            cur.kind <= SEL_NONE;
            cur.idx  <= '0;
        end else begin
            stg_v[0] <= accept;
            stg_s[0] <= dec;
            for (int k = 1; k < NSTG; k++) begin
                stg_v[k] <= stg_v[k-1];
                stg_s[k] <= stg_s[k-1];
            end
            if (stg_v[NSTG-1]) begin
                cur <= stg_s[NSTG-1];
            end
        end
    end

endmodule

// File: rtl/mqw_wr_issue.sv
module mqw_wr_issue
    import mqw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  sel_t              cur,
    input  logic [DATA_W-1:0] wr_data,
    output logic              q_wr,
    output logic [QUEUE_AW-1:0] q_idx,
    output logic [DATA_W-1:0] q_data
);

    logic go;

    always_comb begin
        go = ~wr_en_n & (cur.kind == SEL_HIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_wr   <= 1'b0;
            q_idx  <= '0;
            q_data <= '0;
        end else begin
            q_wr <= go;
            if (go) begin
                q_idx  <= cur.idx;
                q_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mqw_write_selector.sv
module mqw_write_selector
    import mqw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_done,
    input  logic [DEVID_W-1:0]  dev_id,
    input  logic                sel_en,
    input  logic                flag_stb,
    input  logic                wr_en_n,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                q_wr,
    output logic [QUEUE_AW-1:0] q_idx,
    output logic [DATA_W-1:0]   q_data,
    output logic                sel_err
);

    logic accept;
    sel_t dec;
    sel_t cur;

    mqw_sel_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cfg_done (cfg_done),
        .dev_id   (dev_id),
        .sel_en   (sel_en),
        .flag_stb (flag_stb),
        .wr_addr  (wr_addr),
        .accept   (accept),
        .dec      (dec),
        .sel_err  (sel_err)
    );

    mqw_sel_pipe u_pipe (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .dec    (dec),
        .cur    (cur)
    );

    mqw_wr_issue u_issue (
        .clk     (clk),
        .rst     (rst),
        .wr_en_n (wr_en_n),
        .cur     (cur),
        .wr_data (wr_data),
        .q_wr    (q_wr),
        .q_idx   (q_idx),
        .q_data  (q_data)
    );

endmodule

// File: rtl/mqw_checker.sv
module mqw_checker
    import mqw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_en,
    input logic              flag_stb,
    input logic              wr_en_n,
    input logic [DATA_W-1:0] wr_data,
    input logic              q_wr,
    input logic [DATA_W-1:0] q_data,
    input logic              sel_err
);

    AST_WR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        q_wr |-> $past(!wr_en_n)); // R10
    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        q_wr |-> (q_data == $past(wr_data))); // R10
    AST_ERR_ON_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (sel_en && flag_stb) |=> sel_err); // R9
    AST_ERR_ONLY_ON_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        !(sel_en && flag_stb) |=> !sel_err); // R9

endmodule

bind mqw_write_selector mqw_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_en   (sel_en),
    .flag_stb (flag_stb),
    .wr_en_n  (wr_en_n),
    .wr_data  (wr_data),
    .q_wr     (q_wr),
    .q_data   (q_data),
    .sel_err  (sel_err)
);

// File: tb/test_mqw_write_selector.sv
module test_mqw_write_selector;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] MY_ID = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_done = 1'b0;
    logic [2:0]  dev_id = MY_ID;
    logic        sel_en = 1'b0;
    logic        flag_stb = 1'b0;
    logic        wr_en_n = 1'b1;
    logic [7:0]  wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic        q_wr;
    logic [4:0]  q_idx;
    logic [35:0] q_data;
    logic        sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_cur = -1;
    int m_p1  = -1;
    bit m_p1v = 0;
    bit e_wr  = 0;
    int e_idx = 0;
    logic [35:0] e_data = '0;
    bit e_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mqw_write_selector i_mqw_write_selector (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .dev_id(dev_id),
        .sel_en(sel_en), .flag_stb(flag_stb), .wr_en_n(wr_en_n),
        .wr_addr(wr_addr), .wr_data(wr_data), .q_wr(q_wr), .q_idx(q_idx),
        .q_data(q_data), .sel_err(sel_err)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cur = -1; m_p1v = 0; m_p1 = -1;
            e_wr = 0; e_err = 0;
        end else begin
            e_wr   = !wr_en_n && (m_cur >= 0);
            if (e_wr) begin
                e_idx  = m_cur;
                e_data = wr_data;
            end
            e_err  = sel_en && flag_stb;
            if (m_p1v) m_cur = m_p1;
            m_p1v = sel_en && cfg_done && !flag_stb;
            m_p1  = (wr_addr[7:5] == dev_id) ? int'(wr_addr[4:0]) : -1;
        end
    end

    task automatic chk(input string req);
        checks++;
        if (q_wr !== e_wr || sel_err !== e_err ||
            (e_wr && (q_idx !== e_idx[4:0] || q_data !== e_data))) begin
            fails++;
            $display("FAIL %s: got wr=%0b idx=%0d data=%h err=%0b, expected wr=%0b idx=%0d data=%h err=%0b",
                     req, q_wr, q_idx, q_data, sel_err, e_wr, e_idx, e_data, e_err);
        end
    endtask

    task automatic step(input bit sel, input bit wen_n, input logic [2:0] dv,
                        input logic [4:0] q, input bit flg, input string req);
        sel_en   = sel;
        wr_en_n  = wen_n;
        wr_addr  = {dv, q};
        flag_stb = flg;
        wr_data  = wr_data + 36'h1_0000_0011;
        @(posedge clk);
        @(negedge clk);
        chk(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 during reset");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 after reset");

        step(0, 0, MY_ID, 5'd0, 0, "R2 write before selection");
        step(0, 0, MY_ID, 5'd0, 0, "R2 write before selection");

        step(1, 0, MY_ID, 5'd3, 0, "R3 select before config");
        step(0, 0, MY_ID, 5'd0, 0, "R3 ignored select");
        step(0, 0, MY_ID, 5'd0, 0, "R3 ignored select");
        step(0, 0, MY_ID, 5'd0, 0, "R3 ignored select");

        cfg_done = 1'b1;
        step(1, 0, MY_ID, 5'd7, 0, "R2 select edge, no queue yet");
        step(0, 0, MY_ID, 5'd0, 0, "R2 second edge, no queue yet");
        step(0, 0, MY_ID, 5'd0, 0, "R4 R6 first write to queue 7");

        step(1, 0, MY_ID, 5'd12, 0, "R5 select edge old queue");
        step(0, 0, MY_ID, 5'd0, 0, "R5 next edge old queue");
        step(0, 0, MY_ID, 5'd0, 0, "R6 new queue 12");
        step(0, 0, MY_ID, 5'd0, 0, "R10 steady write");

        step(1, 1, MY_ID, 5'd20, 0, "R7 select without write");
        step(0, 1, MY_ID, 5'd0, 0, "R7 idle");
        step(0, 0, MY_ID, 5'd0, 0, "R7 write to queue 20");

        step(1, 0, MY_ID, 5'd1, 1, "R9 collide select and flag");
        step(0, 0, MY_ID, 5'd0, 0, "R9 error pulse ends");
        step(0, 0, MY_ID, 5'd0, 0, "R9 queue unchanged");
        step(0, 1, MY_ID, 5'd0, 1, "R9 flag alone no error");

        step(1, 0, MY_ID, 5'd2, 0, "R11 first select");
        step(1, 0, MY_ID, 5'd3, 0, "R11 second select");
        step(0, 0, MY_ID, 5'd0, 0, "R11 queue 2");
        step(0, 0, MY_ID, 5'd0, 0, "R11 queue 3");

        step(1, 0, 3'd2, 5'd9, 0, "R8 mismatch select edge");
        step(0, 0, MY_ID, 5'd0, 0, "R8 old queue still");
        step(0, 0, MY_ID, 5'd0, 0, "R8 deselected");
        step(0, 0, MY_ID, 5'd0, 0, "R8 deselected");

        step(1, 1, MY_ID, 5'd31, 0, "R4 select queue 31");
        step(0, 0, MY_ID, 5'd0, 0, "R8 no strobe until propagated");
        step(0, 0, MY_ID, 5'd0, 0, "R4 queue 31");

        step(1, 0, MY_ID, 5'd0, 0, "R4 select queue 0");
        step(0, 1, MY_ID, 5'd0, 0, "R10 no write");
        step(0, 0, MY_ID, 5'd0, 0, "R4 queue 0");
        step(0, 0, MY_ID, 5'd0, 0, "R10 data");

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset again");
        rst = 1'b0;
        step(0, 0, MY_ID, 5'd0, 0, "R2 no queue after reset");
        step(0, 0, MY_ID, 5'd0, 0, "R2 no queue after reset");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule